// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block resolves control flow for a 32-bit RISC-V integer core. Each cycle it takes the current program counter, the two source register values, an already-extracted immediate, a two-bit control class and a three-bit branch condition code. One clock edge later it presents four results. The first is the address of the next instruction. The second is a flag saying whether control left the sequential path. The third is the link value that a jump writes back. The fourth is a flag for a target that is not on a 4-byte boundary.

The unit sits between decode and fetch. Decode supplies the class and condition fields, and the register file supplies the operands. Fetch consumes the registered next PC. The trap logic consumes the misaligned flag. Instruction decode, immediate extraction and the register file are not part of this block.

The compare logic has two variants. One derives all six conditions from a single wide subtractor. The other uses separate comparators. A parameter picks the variant; the results are identical.

Top module: `next_pc_unit`

## Requirements
- R1: While rst_ni is low, next_pc_o, link_o, taken_o and misalign_o are all zero.
- R2: Every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).
- R3: Class 2'b00 (sequential) gives next_pc_o = pc_i + 4, taken_o = 0 and misalign_o = 0.
- R4: Class 2'b01 (conditional branch) with cond_i 3'b000 is taken when rs1_i equals rs2_i. With cond_i 3'b001 it is taken when they differ.
- R5: cond_i 3'b100 is taken when rs1_i < rs2_i as two's-complement numbers. cond_i 3'b101 is taken when rs1_i >= rs2_i as two's-complement numbers.
- R6: cond_i 3'b110 is taken when rs1_i < rs2_i as unsigned numbers, with bit 31 weighted as magnitude. cond_i 3'b111 is taken when rs1_i >= rs2_i as unsigned numbers.
- R7: A conditional branch with cond_i 3'b010 or 3'b011 is never taken.
- R8: A taken branch gives next_pc_o = pc_i + imm_i. A branch that is not taken gives next_pc_o = pc_i + 4 and taken_o = 0.
- R9: Class 2'b10 (PC-relative jump) gives taken_o = 1 and next_pc_o = pc_i + imm_i.
- R10: Class 2'b11 (register jump) gives taken_o = 1 and next_pc_o = rs1_i + imm_i with bit 0 forced to 0.
- R11: For every class, link_o = pc_i + 4.
- R12: misalign_o is 1 exactly when taken_o is 1 and next_pc_o[1:0] is not 2'b00.
- R13: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| rs1_i | input | 32 | First source register value |
| rs2_i | input | 32 | Second source register value |
| imm_i | input | 32 | Sign-extended immediate from decode |
| class_i | input | 2 | 00 sequential, 01 branch, 10 PC-relative jump, 11 register jump |
| cond_i | input | 3 | Branch condition code, used only for class 01 |
| next_pc_o | output | 32 | Registered next instruction address |
| link_o | output | 32 | Registered return address pc_i + 4 |
| taken_o | output | 1 | Registered redirect flag |
| misalign_o | output | 1 | Registered flag for a redirect target off a 4-byte boundary |

## Verification
The bench sweeps every condition code against every pair drawn from a set of sign-boundary operands: 0, 1, the largest positive value, the most negative value and all ones. A signed/unsigned mix-up therefore flips the taken flag when exactly one operand has bit 31 set. A wrong subtractor carry breaks the unsigned compares at the all-ones edge.

Register jumps are driven with odd sums. A design that skips the bit-0 clear shows an odd next PC. A design that clears bit 0 before the addition shows a wrong target.

Program counters near the top of the address space check that the sums wrap rather than saturate. Not-taken branches with misaligned immediates check that the misaligned flag stays low when no redirect happens.

// File: rtl/nextpc_pkg.sv
`timescale 1ns/1ps
package nextpc_pkg;

  typedef enum logic [1:0] {
    CLS_SEQ  = 2'b00,
    CLS_BR   = 2'b01,
    CLS_JAL  = 2'b10,
    CLS_JALR = 2'b11
  } flow_class_e;

  typedef enum logic [2:0] {
    CND_EQ   = 3'b000,
    CND_NE   = 3'b001,
    CND_RS0  = 3'b010,
    CND_RS1  = 3'b011,
    CND_LT   = 3'b100,
    CND_GE   = 3'b101,
    CND_LTU  = 3'b110,
    CND_GEU  = 3'b111
  } br_cond_e;

endpackage

// File: rtl/nextpc_cmp.sv
`timescale 1ns/1ps
module nextpc_cmp
  import nextpc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit SUB_CMP = 1'b1
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  br_cond_e        cond_i,
  output logic            hit_o
);

  localparam int MSB = XLEN - 1;

  logic eq, lt, ltu;

  generate
    if (SUB_CMP) begin : g_sub
      // one XLEN+1 subtractor; borrow gives unsigned order
      logic [XLEN:0] diff;
      assign diff = {1'b0, a_i} - {1'b0, b_i};
      assign ltu  = diff[XLEN];
      assign eq   = (diff[MSB:0] == '0);
      // differing signs: the negative operand is smaller
      assign lt   = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : ltu;
    end else begin : g_direct
      assign eq  = (a_i == b_i);
      assign ltu = (a_i < b_i);
      assign lt  = ($signed(a_i) < $signed(b_i));
    end
  endgenerate

  always_comb begin
    unique case (cond_i)
      CND_EQ:  hit_o = eq;
      CND_NE:  hit_o = ~eq;
      CND_LT:  hit_o = lt;
      CND_GE:  hit_o = ~lt;
      CND_LTU: hit_o = ltu;
      CND_GEU: hit_o = ~ltu;
      default: hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/nextpc_target.sv
`timescale 1ns/1ps
module nextpc_target
  import nextpc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] imm_i,
  input  flow_class_e     class_i,
  output logic [XLEN-1:0] seq_o,
  output logic [XLEN-1:0] tgt_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] base, sum;
  logic            reg_rel;

  assign reg_rel = (class_i == CLS_JALR);
  // one shared adder, base muxed in front of it
  assign base    = reg_rel ? rs1_i : pc_i;
  assign sum     = base + imm_i;
  assign tgt_o   = {sum[XLEN-1:1], sum[0] & ~reg_rel};
  assign seq_o   = pc_i + STEP;

endmodule

// File: rtl/next_pc_unit.sv
`timescale 1ns/1ps
module next_pc_unit
  import nextpc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4,
  parameter bit SUB_CMP    = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [31:0]     pc_i,
  input  logic [31:0]     rs1_i,
  input  logic [31:0]     rs2_i,
  input  logic [31:0]     imm_i,
  input  logic [1:0]      class_i,
  input  logic [2:0]      cond_i,
  output logic [31:0]     next_pc_o,
  output logic [31:0]     link_o,
  output logic            taken_o,
  output logic            misalign_o
);

  localparam int ALIGN_LSB = $clog2(INSN_BYTES);

  flow_class_e cls;
  br_cond_e    cnd;
  logic [XLEN-1:0] seq_pc, tgt_pc, nxt_d;
  logic            br_hit, taken_d, mis_d;

  assign cls = flow_class_e'(class_i);
  assign cnd = br_cond_e'(cond_i);

  nextpc_cmp #(.XLEN(XLEN), .SUB_CMP(SUB_CMP)) i_cmp (
    .a_i   (rs1_i),
    .b_i   (rs2_i),
    .cond_i(cnd),
    .hit_o (br_hit)
  );

  nextpc_target #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) i_tgt (
    .pc_i   (pc_i),
    .rs1_i  (rs1_i),
    .imm_i  (imm_i),
    .class_i(cls),
    .seq_o  (seq_pc),
    .tgt_o  (tgt_pc)
  );

  always_comb begin
    unique case (cls)
      CLS_SEQ:  taken_d = 1'b0;
      CLS_BR:   taken_d = br_hit;
      default:  taken_d = 1'b1;
    endcase
    nxt_d = taken_d ? tgt_pc : seq_pc;
    mis_d = taken_d & (|tgt_pc[ALIGN_LSB-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o  <= '0;
      link_o     <= '0;
      taken_o    <= 1'b0;
      misalign_o <= 1'b0;
    end else begin
      next_pc_o  <= nxt_d;
      link_o     <= seq_pc;
      taken_o    <= taken_d;
      misalign_o <= mis_d;
    end
  end

endmodule

// File: rtl/next_pc_chk.sv
`timescale 1ns/1ps
module next_pc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_i,
  input logic [1:0]  class_i,
  input logic [2:0]  cond_i,
  input logic [31:0] next_pc_o,
  input logic [31:0] link_o,
  input logic        taken_o,
  input logic        misalign_o
);

  // high once the previous edge saw reset released
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R11
  link_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> link_o == $past(pc_i) + 32'd4);

  // R3
  seq_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(class_i) == 2'b00) |-> (!taken_o && next_pc_o == $past(pc_i) + 32'd4));

  // R7
  rsvd_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(class_i) == 2'b01 && $past(cond_i[2:1]) == 2'b01) |-> !taken_o);

  // R9
  jump_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(class_i[1])) |-> taken_o);

  // R10
  jalr_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(class_i) == 2'b11) |-> !next_pc_o[0]);

  // R12
  misalign_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (taken_o && next_pc_o[1:0] != 2'b00));

  // R8
  not_taken_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !taken_o) |-> next_pc_o == link_o);

endmodule

bind next_pc_unit next_pc_chk i_next_pc_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pc_i      (pc_i),
  .class_i   (class_i),
  .cond_i    (cond_i),
  .next_pc_o (next_pc_o),
  .link_o    (link_o),
  .taken_o   (taken_o),
  .misalign_o(misalign_o)
);

// File: tb/test_next_pc_unit.sv
`timescale 1ns/1ps
module test_next_pc_unit;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc, rs1, rs2, imm;
  logic [1:0]  cls;
  logic [2:0]  cnd;
  logic [31:0] next_pc, link;
  logic        taken, misalign;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  next_pc_unit i_next_pc_unit (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .pc_i      (pc),
    .rs1_i     (rs1),
    .rs2_i     (rs2),
    .imm_i     (imm),
    .class_i   (cls),
    .cond_i    (cnd),
    .next_pc_o (next_pc),
    .link_o    (link),
    .taken_o   (taken),
    .misalign_o(misalign)
  );

  function automatic logic [31:0] corner(input int k);
    case (k)
      0: corner = 32'h0000_0000;
      1: corner = 32'h0000_0001;
      2: corner = 32'h7fff_ffff;
      3: corner = 32'h8000_0000;
      4: corner = 32'hffff_ffff;
      5: corner = 32'h8000_0001;
      6: corner = 32'hffff_fffe;
      default: corner = 32'h1234_5678;
    endcase
  endfunction

  task automatic apply(input logic [1:0] c, input logic [2:0] cd,
                       input logic [31:0] p, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] im,
                       input string req);
    logic        e_tk, e_mis;
    logic [31:0] e_nx, e_lk, t;
    @(negedge clk);
    cls = c; cnd = cd; pc = p; rs1 = a; rs2 = b; imm = im;
    e_lk = p + 32'd4;
    case (c)
      2'b00: begin e_tk = 1'b0; t = 32'h0; end
      2'b01: begin
        t = p + im;
        case (cd)
          3'd0: e_tk = (a == b);
          3'd1: e_tk = (a != b);
          3'd4: e_tk = ($signed(a) <  $signed(b));
          3'd5: e_tk = ($signed(a) >= $signed(b));
          3'd6: e_tk = (a <  b);
          3'd7: e_tk = (a >= b);
          default: e_tk = 1'b0;
        endcase
      end
      2'b10: begin e_tk = 1'b1; t = p + im; end
      default: begin e_tk = 1'b1; t = (a + im) & 32'hffff_fffe; end
    endcase
    e_nx  = e_tk ? t : e_lk;
    e_mis = e_tk && (e_nx[1:0] != 2'b00);
    @(negedge clk);
    n_vec++;
    if (next_pc !== e_nx || link !== e_lk || taken !== e_tk || misalign !== e_mis) begin
      n_bad++;
      $display("FAIL %s cls=%b cnd=%b pc=%h a=%h b=%h imm=%h got nx=%h lk=%h tk=%b mis=%b exp nx=%h lk=%h tk=%b mis=%b",
               req, c, cd, p, a, b, im, next_pc, link, taken, misalign, e_nx, e_lk, e_tk, e_mis);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    cls = 2'b10; cnd = 3'd0; pc = 32'h1003; rs1 = 32'h55; rs2 = 32'h66; imm = 32'h7;
    repeat (3) @(negedge clk);
    // R1: reset holds every output at zero
    n_vec++;
    if (next_pc !== 32'h0 || link !== 32'h0 || taken !== 1'b0 || misalign !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 got nx=%h lk=%h tk=%b mis=%b exp all zero", next_pc, link, taken, misalign);
    end
    rst_ni = 1'b1;

    // R4 R5 R6 R7 R8: every condition against every corner pair
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(2'b01, 3'(c), {$urandom} & 32'hffff_fffc, corner(i), corner(j),
                $urandom & 32'h0000_0ffe, "R4/R5/R6/R7/R8");

    // R8 R12: odd offsets on branches, taken or not
    for (int k = 0; k < 64; k++)
      apply(2'b01, 3'(k % 8), 32'h0000_4000, $urandom, $urandom, 32'(k), "R8_R12");

    // R3 R11 R13: sequential, including top-of-space wrap
    for (int k = 0; k < 64; k++)
      apply(2'b00, 3'($urandom), (k < 4) ? 32'hffff_fffc - 32'(4 * k) : $urandom & 32'hffff_fffc,
            $urandom, $urandom, $urandom, "R3_R11_R13");

    // R9 R12 R13: PC-relative jumps, low offset bits swept, negative wrap
    for (int k = 0; k < 64; k++)
      apply(2'b10, 3'($urandom), 32'hffff_fff0, $urandom, $urandom,
            (k % 2 == 0) ? 32'(k) : -32'(k), "R9_R12_R13");

    // R10 R12: register jumps, odd sums exercise bit-0 clear
    for (int k = 0; k < 64; k++)
      apply(2'b11, 3'($urandom), $urandom & 32'hffff_fffc, 32'h8000_0000 + 32'(k % 8),
            $urandom, 32'(k / 8) - 32'd3, "R10_R12");

    // R2: back-to-back vectors of different class
    for (int k = 0; k < 32; k++)
      apply(2'(k), 3'(k >> 2), $urandom, $urandom, $urandom, $urandom, "R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule